// File: doc/BRIEF.md
# Dual Configuration Space Shadow Window

This block holds two 64-byte configuration spaces and exposes them to a big-endian host through a special address region. The first space belongs to a host-to-PCI bridge and the second to a graphics controller. Each host access carries an address, a size, a read or write strobe and write data. The block decides whether the access is a configuration access, steers it to one of the two spaces, and packs or unpacks multi-byte values so that the lowest offset maps to the most significant byte.

Two rules keep the spaces consistent. Every write to the graphics space is followed at once by a fixup that restores the identification, class and status fields that software may not change. Every write to the bridge space recomputes two video-memory bank base values from two bytes of that space. These bank bases drive the memory mapper of the surrounding design.

Read data is registered. It is valid on the clock after the read strobe and holds until the next read.

Top module: `cfg_shadow_window`

## Requirements
- R1: An access whose address is at least 0x400000 is a configuration access, whatever the mode inputs are.
- R2: An access below 0x400000 is a configuration access only when narrowBus=1, mapRam=0 and unmapFlash=1, and the full address lies in 0x800–0xBFF or 0x1000–0x1FFF. Any other access below 0x400000 is not a configuration access.
- R3: Within a configuration access, address bits 15:0 pick the space. Offsets 0x0800–0x083F reach the bridge space at byte (offset−0x800), and offsets 0x1000–0x103F reach the graphics space at byte (offset−0x1000).
- R4: size encodes 0=byte, 1=word, 2 or 3=long. Data is right-justified on wrData and rdData, and multi-byte values are big-endian: the lowest byte offset travels in the most significant byte.
- R5: After reset and after every write to the graphics space, graphics bytes 0..11 read 00 B8 10 13 02 00 00 xx 03 00 00 44, where byte 7 keeps its written value.
- R6: The same fixup clears bits 0, 1 and 5 of graphics byte 7, and bit 0 of graphics bytes 0x10 and 0x13. All other bits of those bytes, and every other graphics byte, keep the written value.
- R7: A write to the bridge space sets bankBase0 to bridge byte 0x12 in bits 23:16 and bankBase1 to bridge byte 0x16 in bits 23:16, with all other bits zero. Both values reflect the new contents on the clock after the write.
- R8: A read that is not a configuration access, or that hits neither space, returns 0. A write that hits neither space changes no stored byte.
- R9: Reset clears the bridge space, rdData and both bank bases to zero, and loads the graphics space with zeros plus the fixup.
- R10: rdData updates only on the clock after rdEn and holds its value otherwise.
- R11: bankBase0 and bankBase1 change only after a write to the bridge space. Writes to the graphics space leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 24 | Masked host byte address |
| size | input | 2 | Access size: 0 byte, 1 word, 2/3 long |
| rdEn | input | 1 | Read strobe, one cycle per access |
| wrEn | input | 1 | Write strobe, one cycle per access |
| wrData | input | 32 | Right-justified write data |
| narrowBus | input | 1 | Narrow-bus host mode |
| mapRam | input | 1 | Register RAM mapped into the low region |
| unmapFlash | input | 1 | Boot flash removed from the low region |
| rdData | output | 32 | Registered, right-justified read data |
| bankBase0 | output | 32 | Bank base derived from bridge byte 0x12 |
| bankBase1 | output | 32 | Bank base derived from bridge byte 0x16 |

## Verification
The assertions assume that rdEn and wrEn are never high in the same cycle, and that the reset input starts low so that no state is examined before the first reset. The hold checks also take a quiet cycle to mean a cycle with no strobe, so any write, mapped or not, opens the window in which a bank base may move. The stimulus drives each access as a single-cycle strobe and returns both strobes to zero between accesses. Multi-byte accesses use offsets aligned to their size, so no access runs past the end of a space.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  localparam int CFG_SPACE_BYTES = 64;
  localparam int OFS_W = $clog2(CFG_SPACE_BYTES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_LONGX = 2'b11
  } accSize_t;

  // control -> datapath strobes
  typedef struct packed {
    logic             rdGo;
    logic             wrBridge;
    logic             wrChip;
    logic             selBridge;
    logic             selChip;
    logic [OFS_W-1:0] ofs;
    logic [2:0]       laneCnt;
  } cfgStrobe_t;

endpackage

// File: rtl/cfgwin_ctrl.sv
module cfgwin_ctrl
  import cfgwin_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] HIGH_BASE = 24'h400000,
  parameter logic [15:0] BRIDGE_BASE = 16'h0800,
  parameter logic [15:0] CHIP_BASE = 16'h1000,
  parameter logic [ADDR_W-1:0] LOWA_LO = 24'h000800,
  parameter logic [ADDR_W-1:0] LOWA_HI = 24'h000C00,
  parameter logic [ADDR_W-1:0] LOWB_LO = 24'h001000,
  parameter logic [ADDR_W-1:0] LOWB_HI = 24'h002000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic              narrowBus,
  input  logic              mapRam,
  input  logic              unmapFlash,
  output cfgStrobe_t        strobe
);

  localparam int TAG_W = 16 - OFS_W;
  localparam logic [TAG_W-1:0] BRIDGE_TAG = BRIDGE_BASE[15:OFS_W];
  localparam logic [TAG_W-1:0] CHIP_TAG = CHIP_BASE[15:OFS_W];

  logic [15:0] low16;
  logic inLowWin;
  logic lowEnable;
  logic isCfg;
  logic hitBridge;
  logic hitChip;
  accSize_t sz;

  always_comb begin
    low16 = addr[15:0];
    sz = accSize_t'(size);
    inLowWin = ((addr >= LOWA_LO) && (addr < LOWA_HI)) ||
               ((addr >= LOWB_LO) && (addr < LOWB_HI));
    lowEnable = narrowBus && !mapRam && unmapFlash;
    isCfg = (addr >= HIGH_BASE) || (lowEnable && inLowWin);
    hitBridge = isCfg && (low16[15:OFS_W] == BRIDGE_TAG);
    hitChip = isCfg && (low16[15:OFS_W] == CHIP_TAG);

    strobe.rdGo = rdEn;
    strobe.wrBridge = wrEn && hitBridge;
    strobe.wrChip = wrEn && hitChip;
    strobe.selBridge = hitBridge;
    strobe.selChip = hitChip;
    strobe.ofs = low16[OFS_W-1:0];
    unique case (sz)
      SZ_BYTE: strobe.laneCnt = 3'd1;
      SZ_WORD: strobe.laneCnt = 3'd2;
      default: strobe.laneCnt = 3'd4;
    endcase
  end

endmodule

// File: rtl/cfgwin_dp.sv
module cfgwin_dp
  import cfgwin_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BANK0_IDX = 'h12,
  parameter int BANK1_IDX = 'h16,
  parameter int BANK_SHIFT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] bankBase0,
  output logic [DATA_W-1:0] bankBase1
);

  localparam int LANES = DATA_W / 8;

  logic [7:0] bridgeMem [CFG_SPACE_BYTES];
  logic [7:0] chipMem [CFG_SPACE_BYTES];
  logic [7:0] bridgeNext [CFG_SPACE_BYTES];
  logic [7:0] chipNext [CFG_SPACE_BYTES];
  logic [DATA_W-1:0] rdValue;

  // protected fields of the graphics space
  function automatic logic [7:0] fixByte(input int idx, input logic [7:0] b);
    case (idx)
      0:       return 8'h00;
      1:       return 8'hB8;
      2:       return 8'h10;
      3:       return 8'h13;
      4:       return 8'h02;
      5, 6:    return 8'h00;
      7:       return b & ~8'h23;
      8:       return 8'h03;
      9, 10:   return 8'h00;
      11:      return 8'h44;
      16, 19:  return b & ~8'h01;
      default: return b;
    endcase
  endfunction

  // merge write lanes, then fixup
  always_comb begin
    bridgeNext = bridgeMem;
    chipNext = chipMem;
    for (int i = 0; i < LANES; i++) begin
      logic [OFS_W-1:0] idx;
      int k;
      idx = strobe.ofs + OFS_W'(i);
      k = int'(strobe.laneCnt) - 1 - i;
      if (k >= 0) begin
        if (strobe.wrBridge) bridgeNext[idx] = wrData[8*k +: 8];
        if (strobe.wrChip) chipNext[idx] = wrData[8*k +: 8];
      end
    end
    if (strobe.wrChip) begin
      for (int j = 0; j < CFG_SPACE_BYTES; j++) chipNext[j] = fixByte(j, chipNext[j]);
    end
  end

  // read assembly, big-endian
  always_comb begin
    rdValue = '0;
    for (int i = 0; i < LANES; i++) begin
      logic [OFS_W-1:0] idx;
      int k;
      idx = strobe.ofs + OFS_W'(i);
      k = int'(strobe.laneCnt) - 1 - i;
      if (k >= 0) begin
        if (strobe.selBridge) rdValue[8*k +: 8] = bridgeMem[idx];
        else if (strobe.selChip) rdValue[8*k +: 8] = chipMem[idx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < CFG_SPACE_BYTES; j++) begin
        bridgeMem[j] <= 8'h00;
        chipMem[j] <= fixByte(j, 8'h00);
      end
      rdData <= '0;
      bankBase0 <= '0;
      bankBase1 <= '0;
    end else begin
      bridgeMem <= bridgeNext;
      chipMem <= chipNext;
      if (strobe.wrBridge) begin
        bankBase0 <= DATA_W'(bridgeNext[BANK0_IDX]) << BANK_SHIFT;
        bankBase1 <= DATA_W'(bridgeNext[BANK1_IDX]) << BANK_SHIFT;
      end
      if (strobe.rdGo) rdData <= rdValue;
    end
  end

endmodule

// File: rtl/cfg_shadow_window.sv
module cfg_shadow_window
  import cfgwin_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              narrowBus,
  input  logic              mapRam,
  input  logic              unmapFlash,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] bankBase0,
  output logic [DATA_W-1:0] bankBase1
);

  cfgStrobe_t strobe;

  cfgwin_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .addr(addr),
    .size(size),
    .rdEn(rdEn),
    .wrEn(wrEn),
    .narrowBus(narrowBus),
    .mapRam(mapRam),
    .unmapFlash(unmapFlash),
    .strobe(strobe)
  );

  cfgwin_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .wrData(wrData),
    .rdData(rdData),
    .bankBase0(bankBase0),
    .bankBase1(bankBase1)
  );

endmodule

// File: rtl/cfgwin_chk.sv
module cfgwin_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        size,
  input logic              rdEn,
  input logic              wrEn,
  input logic [DATA_W-1:0] rdData,
  input logic [DATA_W-1:0] bankBase0,
  input logic [DATA_W-1:0] bankBase1
);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rdEn) |-> $stable(rdData));

  // R11
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrEn) |-> ($stable(bankBase0) && $stable(bankBase1)));

  // R7
  bank_fmt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bankBase0[15:0] == 16'h0) && (bankBase0[31:24] == 8'h0) &&
    (bankBase1[15:0] == 16'h0) && (bankBase1[31:24] == 8'h0));

  // R5
  chip_id_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && (addr >= 24'h400000) && (addr[15:0] == 16'h1000) && (size == 2'b10))
    |=> (rdData == 32'h00B81013));

  // R8
  miss_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && (addr >= 24'h400000) && (addr[15:0] >= 16'h2000)) |=> (rdData == '0));

endmodule

bind cfg_shadow_window cfgwin_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk),
  .rstN(rstN),
  .addr(addr),
  .size(size),
  .rdEn(rdEn),
  .wrEn(wrEn),
  .rdData(rdData),
  .bankBase0(bankBase0),
  .bankBase1(bankBase1)
);

// File: tb/sim_cfg_shadow_window.sv
module sim_cfg_shadow_window;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [23:0] addr = '0;
  logic [1:0] size = '0;
  logic rdEn = 1'b0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic narrowBus = 1'b0;
  logic mapRam = 1'b0;
  logic unmapFlash = 1'b0;
  logic [31:0] rdData;
  logic [31:0] bankBase0;
  logic [31:0] bankBase1;

  int nChecks = 0;
  int nFails = 0;

  localparam logic [23:0] HI = 24'h400000;

  always #4 clk = ~clk;

  cfg_shadow_window u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .size(size), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .narrowBus(narrowBus), .mapRam(mapRam), .unmapFlash(unmapFlash),
    .rdData(rdData), .bankBase0(bankBase0), .bankBase1(bankBase1)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [23:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    addr = a; size = s; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [23:0] a, input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    addr = a; size = s; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic testReset();
    logic [31:0] v;
    check("R9 rdData after reset", rdData, 32'h0);
    check("R9 bankBase0 after reset", bankBase0, 32'h0);
    check("R9 bankBase1 after reset", bankBase1, 32'h0);
    doRead(HI | 24'h1000, 2'd2, v); check("R5 R9 chip bytes 0-3", v, 32'h00B81013);
    doRead(HI | 24'h1004, 2'd2, v); check("R5 R9 chip bytes 4-7", v, 32'h02000000);
    doRead(HI | 24'h1008, 2'd2, v); check("R5 R9 chip bytes 8-11", v, 32'h03000044);
    doRead(HI | 24'h0800, 2'd2, v); check("R9 bridge cleared", v, 32'h0);
  endtask

  task automatic testChipFixup();
    logic [31:0] v;
    doWrite(HI | 24'h1000, 2'd2, 32'hFFFFFFFF);
    doRead(HI | 24'h1000, 2'd2, v); check("R5 ID forced after write", v, 32'h00B81013);
    doWrite(HI | 24'h1004, 2'd2, 32'hFFFFFFFF);
    doRead(HI | 24'h1004, 2'd2, v); check("R6 byte7 bits cleared", v, 32'h020000DC);
    doWrite(HI | 24'h1008, 2'd3, 32'h55555555);
    doRead(HI | 24'h1008, 2'd2, v); check("R5 bytes 8-11 forced", v, 32'h03000044);
    doWrite(HI | 24'h1010, 2'd2, 32'hFFFFFFFF);
    doRead(HI | 24'h1010, 2'd2, v); check("R6 bytes 0x10/0x13 bit0", v, 32'hFEFFFFFE);
  endtask

  task automatic testEndian();
    logic [31:0] v;
    doWrite(HI | 24'h1020, 2'd2, 32'h12345678);
    doRead(HI | 24'h1020, 2'd2, v); check("R4 long readback", v, 32'h12345678);
    doRead(HI | 24'h1022, 2'd1, v); check("R4 word low half", v, 32'h00005678);
    doRead(HI | 24'h1021, 2'd0, v); check("R4 byte order", v, 32'h00000034);
    doWrite(HI | 24'h1024, 2'd1, 32'h0000ABCD);
    doRead(HI | 24'h1024, 2'd0, v); check("R4 word write msb first", v, 32'h000000AB);
  endtask

  task automatic testBank();
    logic [31:0] v;
    doWrite(HI | 24'h0810, 2'd2, 32'hAABBCCDD);
    check("R7 bankBase0 from long", bankBase0, 32'h00CC0000);
    check("R7 bankBase1 unchanged byte", bankBase1, 32'h00000000);
    doWrite(HI | 24'h0816, 2'd1, 32'h00005A77);
    check("R7 bankBase1 from word", bankBase1, 32'h005A0000);
    doWrite(HI | 24'h0812, 2'd0, 32'h00000011);
    check("R7 bankBase0 from byte", bankBase0, 32'h00110000);
    doRead(HI | 24'h0810, 2'd2, v); check("R3 R4 bridge readback", v, 32'hAABB11DD);
    doWrite(HI | 24'h1012, 2'd0, 32'h00000099);
    check("R11 chip write keeps bankBase0", bankBase0, 32'h00110000);
    check("R11 chip write keeps bankBase1", bankBase1, 32'h005A0000);
    doRead(HI | 24'h1012, 2'd0, v); check("R3 chip byte 0x12", v, 32'h00000099);
  endtask

  task automatic testMiss();
    logic [31:0] v;
    doWrite(HI | 24'h1060, 2'd2, 32'hFFFFFFFF);
    doRead(HI | 24'h1020, 2'd2, v); check("R8 ignored write chip alias", v, 32'h12345678);
    doWrite(HI | 24'h0860, 2'd2, 32'hFFFFFFFF);
    doRead(HI | 24'h0820, 2'd2, v); check("R8 ignored write bridge alias", v, 32'h0);
    check("R8 R11 miss write keeps bank", bankBase0, 32'h00110000);
    doRead(HI | 24'h1060, 2'd2, v); check("R8 miss read", v, 32'h0);
    doRead(HI | 24'h3000, 2'd2, v); check("R8 far miss read", v, 32'h0);
  endtask

  task automatic testLowWindow();
    logic [31:0] v;
    narrowBus = 1'b1; mapRam = 1'b0; unmapFlash = 1'b1;
    doRead(24'h001000, 2'd2, v); check("R2 low chip read enabled", v, 32'h00B81013);
    doRead(24'h000810, 2'd2, v); check("R2 low bridge read enabled", v, 32'hAABB11DD);
    doRead(24'h011000, 2'd2, v); check("R2 outside low range", v, 32'h0);
    mapRam = 1'b1;
    doRead(24'h001000, 2'd2, v); check("R2 mapRam blocks", v, 32'h0);
    doWrite(24'h000812, 2'd0, 32'h00000077);
    check("R2 blocked write keeps bank", bankBase0, 32'h00110000);
    doRead(HI | 24'h1000, 2'd2, v); check("R1 high region under mapRam", v, 32'h00B81013);
    mapRam = 1'b0; narrowBus = 1'b0;
    doRead(24'h001000, 2'd2, v); check("R2 narrowBus required", v, 32'h0);
    narrowBus = 1'b1; unmapFlash = 1'b0;
    doRead(24'h001000, 2'd2, v); check("R2 unmapFlash required", v, 32'h0);
    unmapFlash = 1'b0; narrowBus = 1'b0;
  endtask

  task automatic testHold();
    logic [31:0] v;
    doRead(HI | 24'h0810, 2'd2, v);
    @(negedge clk); addr = HI | 24'h1000; size = 2'd2;
    repeat (3) @(negedge clk);
    check("R10 rdData held without rdEn", rdData, 32'hAABB11DD);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testChipFixup();
    testEndian();
    testBank();
    testMiss();
    testLowWindow();
    testHold();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h1, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule